// File: doc/BRIEF.md
# Capture/Reload Timer with Baud Clock Output

This block is a 16-bit up-counter with a 16-bit companion register. It can capture the count on an external trigger, reload the count on overflow or on a trigger, or run as a baud-rate divider whose overflow pulses clock a serial port's transmitter and receiver. One control byte selects the mode, enables counting, picks the count source and holds two sticky event flags. The two flags are ORed into a single interrupt request.

The internal count source is a one-cycle tick pulse, `tick_i`. In baud mode a faster pulse, `osc_half_i`, replaces it. The external count source is a pin whose falling edges are counted. A second pin supplies falling-edge triggers. Both pins are synchronised inside the block. Software reaches the registers through a simple byte-wide write/read port. A write takes effect at the next clock edge, and a read returns data combinationally.

Top module: `cap_reload_timer`

## Requirements
- R1: After the active-low asynchronous reset, every register reads 0x00, and `irq_o`, `tx_baud_o` and `rx_baud_o` are 0.
- R2: When control bit 4 or bit 5 is 1, the block is in baud mode and the capture-select bit (bit 2) has no effect. Otherwise, bit 2 = 1 selects capture mode and bit 2 = 0 selects reload mode.
- R3: The counter advances only when the run bit (bit 0) is 1. With bit 1 = 0 it advances on each `tick_i` pulse, or on each `osc_half_i` pulse in baud mode. With bit 1 = 1 it advances once per falling edge of `ext_clk_i`, and the tick inputs are ignored.
- R4: In reload mode, a count step from 0xFFFF loads the counter from the companion register and sets the overflow flag (bit 6).
- R5: In capture mode, a count step from 0xFFFF wraps the counter to 0x0000 and sets bit 6. When the trigger-enable bit (bit 3) is 1, a falling edge on `ext_trig_i` copies the counter into the companion register and sets the trigger flag (bit 7).
- R6: In reload mode with bit 3 = 1, a falling edge on `ext_trig_i` loads the counter from the companion register and sets bit 7, whether or not the run bit is set.
- R7: With bit 3 = 0, edges on `ext_trig_i` change neither the flags, the counter nor the companion register.
- R8: In baud mode, overflow reloads the counter from the companion register and leaves bit 6 unchanged. The cycle after the overflow, `tx_baud_o` pulses high for one cycle if bit 4 is set, and `rx_baud_o` pulses high for one cycle if bit 5 is set.
- R9: Bits 6 and 7 are never cleared by hardware, only by a control write. `irq_o` is high whenever either bit is set.
- R10: When a counter overflow and a qualified trigger fall in the same cycle in capture mode, the companion register receives 0xFFFF and both flags are set. A hardware flag set wins over a control write in the same cycle.
- R11: Register addresses: 0 is the control byte, 1 and 2 are the counter low and high bytes, 3 and 4 are the companion low and high bytes. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Internal count pulse |
| osc_half_i | input | 1 | Internal count pulse used in baud mode |
| ext_clk_i | input | 1 | External count pin, falling edges counted |
| ext_trig_i | input | 1 | External trigger pin, falling edges act |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 1 | Interrupt request, OR of both flags |
| tx_baud_o | output | 1 | Transmit baud clock pulse |
| rx_baud_o | output | 1 | Receive baud clock pulse |

## Verification
Two functions can fall in the same cycle: a count step from 0xFFFF, and a synchronised trigger edge in capture mode. The bench drops the trigger pin two clock edges before it pulses the tick, so the edge detector's output and the count step reach the same clock edge. It then expects the companion register to hold 0xFFFF, the counter to read 0x0000, and both flags to be set. A second collision lands a control write on the same edge as an overflow. The overflow flag must still read as set.

// File: rtl/crt_pkg.sv
`timescale 1ns/1ps
package crt_pkg;
  typedef enum logic [1:0] {
    MODE_RELOAD  = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_BAUD    = 2'd2
  } crt_mode_e;

  localparam int CTL_W = 8;

  localparam logic [2:0] ADDR_CTL    = 3'd0;
  localparam logic [2:0] ADDR_CNT_LO = 3'd1;
  localparam logic [2:0] ADDR_CNT_HI = 3'd2;
  localparam logic [2:0] ADDR_CAP_LO = 3'd3;
  localparam logic [2:0] ADDR_CAP_HI = 3'd4;

  localparam int B_RUN    = 0;
  localparam int B_EXT    = 1;
  localparam int B_CAPSEL = 2;
  localparam int B_TRIGEN = 3;
  localparam int B_TXB    = 4;
  localparam int B_RXB    = 5;
  localparam int B_OVF    = 6;
  localparam int B_TRIG   = 7;

  // baud bits outrank capture select
  function automatic crt_mode_e crt_decode(input logic cap_sel, input logic tx_en,
                                           input logic rx_en);
    if (tx_en || rx_en) return MODE_BAUD;
    else if (cap_sel)   return MODE_CAPTURE;
    else                return MODE_RELOAD;
  endfunction
endpackage

// File: rtl/crt_edge_det.sv
`timescale 1ns/1ps
module crt_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/crt_counter.sv
`timescale 1ns/1ps
module crt_counter
  import crt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  crt_mode_e            mode_i,
  input  logic                 cnt_en_i,
  input  logic                 trig_i,
  input  logic [3:0]           wr_sel_i,  // {cap_hi, cap_lo, cnt_hi, cnt_lo}
  input  logic [CNT_W/2-1:0]   wdata_i,
  output logic [CNT_W-1:0]     cnt_o,
  output logic [CNT_W-1:0]     cap_o,
  output logic                 ovf_o
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_n, cap_q, cap_n;
  logic             wrap;

  assign wrap = cnt_en_i && (cnt_q == CNT_MAX);

  always_comb begin
    cnt_n = cnt_q;
    cap_n = cap_q;
    if (cnt_en_i) begin
      if (wrap) cnt_n = (mode_i == MODE_CAPTURE) ? '0 : cap_q;
      else      cnt_n = cnt_q + CNT_ONE;
    end
    if (trig_i) begin
      case (mode_i)
        MODE_CAPTURE: cap_n = cnt_q;  // pre-step value
        MODE_RELOAD:  cnt_n = cap_q;
        default: ;
      endcase
    end
    for (int h = 0; h < 2; h++) begin
      if (wr_sel_i[h])   cnt_n[h*HALF +: HALF] = wdata_i;
      if (wr_sel_i[2+h]) cap_n[h*HALF +: HALF] = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      cap_q <= cap_n;
    end
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;
  assign ovf_o = wrap;
endmodule

// File: rtl/cap_reload_timer.sv
`timescale 1ns/1ps
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               osc_half_i,
  input  logic               ext_clk_i,
  input  logic               ext_trig_i,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [CNT_W/2-1:0] reg_wdata_i,
  output logic [CNT_W/2-1:0] reg_rdata_o,
  output logic               irq_o,
  output logic               tx_baud_o,
  output logic               rx_baud_o
);
  localparam int DW = CNT_W / 2;

  logic [CTL_W-1:0] ctl_q, ctl_n;
  logic [CNT_W-1:0] cnt_w, cap_w;
  logic [3:0]       wr_sel;
  logic             we_ctl, we_cnt;
  logic             clk_fall, trig_fall, trig_q, src_tick, cnt_en, ovf;
  logic             tx_q, rx_q;
  crt_mode_e        mode;

  crt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_clk_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_clk_i), .fall_o(clk_fall)
  );
  crt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_trig_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(ext_trig_i), .fall_o(trig_fall)
  );

  assign mode   = crt_decode(ctl_q[B_CAPSEL], ctl_q[B_TXB], ctl_q[B_RXB]);
  assign we_ctl = reg_we_i && (reg_addr_i == ADDR_CTL);
  assign wr_sel = {reg_we_i && (reg_addr_i == ADDR_CAP_HI),
                   reg_we_i && (reg_addr_i == ADDR_CAP_LO),
                   reg_we_i && (reg_addr_i == ADDR_CNT_HI),
                   reg_we_i && (reg_addr_i == ADDR_CNT_LO)};
  assign we_cnt = |wr_sel[1:0];

  always_comb begin
    if (ctl_q[B_EXT])           src_tick = clk_fall;
    else if (mode == MODE_BAUD) src_tick = osc_half_i;
    else                        src_tick = tick_i;
  end
  assign cnt_en = ctl_q[B_RUN] && src_tick;
  assign trig_q = trig_fall && ctl_q[B_TRIGEN];

  crt_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode), .cnt_en_i(cnt_en),
    .trig_i(trig_q), .wr_sel_i(wr_sel), .wdata_i(reg_wdata_i),
    .cnt_o(cnt_w), .cap_o(cap_w), .ovf_o(ovf)
  );

  // hardware flag set wins over a same-cycle write
  always_comb begin
    ctl_n = ctl_q;
    if (we_ctl) ctl_n = reg_wdata_i[CTL_W-1:0];
    if (ovf && (mode != MODE_BAUD)) ctl_n[B_OVF] = 1'b1;
    if (trig_q) ctl_n[B_TRIG] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      tx_q  <= 1'b0;
      rx_q  <= 1'b0;
    end else begin
      ctl_q <= ctl_n;
      tx_q  <= ovf && (mode == MODE_BAUD) && ctl_q[B_TXB];
      rx_q  <= ovf && (mode == MODE_BAUD) && ctl_q[B_RXB];
    end
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_CTL:    reg_rdata_o = DW'(ctl_q);
      ADDR_CNT_LO: reg_rdata_o = cnt_w[DW-1:0];
      ADDR_CNT_HI: reg_rdata_o = cnt_w[CNT_W-1:DW];
      ADDR_CAP_LO: reg_rdata_o = cap_w[DW-1:0];
      ADDR_CAP_HI: reg_rdata_o = cap_w[CNT_W-1:DW];
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_o     = ctl_q[B_OVF] | ctl_q[B_TRIG];
  assign tx_baud_o = tx_q;
  assign rx_baud_o = rx_q;
endmodule

// File: rtl/crt_checker.sv
`timescale 1ns/1ps
module crt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       ctl_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             we_ctl_i,
  input logic             we_cnt_i,
  input logic             tx_i,
  input logic             rx_i
);
  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i[6] && !we_ctl_i |=> ctl_i[6]);

  assert_trig_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i[7] && !we_ctl_i |=> ctl_i[7]);

  assert_trig_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i[3] && !ctl_i[7] && !we_ctl_i |=> !ctl_i[7]);

  assert_halt_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_i[0] && !ctl_i[3] && !we_cnt_i |=> $stable(cnt_i));

  assert_baud_no_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i[4] || ctl_i[5]) && !ctl_i[6] && !we_ctl_i |=> !ctl_i[6]);

  assert_tx_enabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_i |-> $past(ctl_i[4]));

  assert_rx_enabled_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_i |-> $past(ctl_i[5]));
endmodule

bind cap_reload_timer crt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctl_i(ctl_q), .cnt_i(cnt_w),
  .we_ctl_i(we_ctl), .we_cnt_i(we_cnt), .tx_i(tx_baud_o), .rx_i(rx_baud_o)
);

// File: tb/cap_reload_timer_bench.sv
`timescale 1ns/1ps
module cap_reload_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, osc = 1'b0, eclk = 1'b0, etrig = 1'b1;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, txb, rxb;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  cap_reload_timer u_cap_reload_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .osc_half_i(osc),
    .ext_clk_i(eclk), .ext_trig_i(etrig), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq),
    .tx_baud_o(txb), .rx_baud_o(rxb)
  );

  // {ctl, cnt0, cap, pulses, exp_cnt, exp_ctl}
  localparam logic [71:0] VEC [6] = '{
    {8'h01, 16'h0000, 16'h0000, 8'd5, 16'h0005, 8'h01},
    {8'h01, 16'hFFFE, 16'h1000, 8'd3, 16'h1001, 8'h41},
    {8'h05, 16'hFFFF, 16'h1000, 8'd2, 16'h0001, 8'h45},
    {8'h11, 16'hFFFD, 16'hFF00, 8'd4, 16'hFF01, 8'h11},
    {8'h25, 16'hFFFF, 16'hABCD, 8'd1, 16'hABCD, 8'h25},
    {8'h00, 16'h0042, 16'h0000, 8'd4, 16'h0042, 8'h00}
  };
  localparam string VTAG [6] = '{"R4", "R4", "R5", "R8", "R2", "R3"};

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic setup(input logic [7:0] c, input logic [15:0] n, input logic [15:0] p);
    wr(3'd0, 8'h00);
    wr(3'd1, n[7:0]); wr(3'd2, n[15:8]);
    wr(3'd3, p[7:0]); wr(3'd4, p[15:8]);
    wr(3'd0, c);
  endtask

  task automatic pulse(input bit use_tick, input bit use_osc);
    @(negedge clk); tick = use_tick; osc = use_osc;
    @(negedge clk); tick = 1'b0; osc = 1'b0;
  endtask

  task automatic trig_edge();
    @(negedge clk); etrig = 1'b0;
    repeat (4) @(negedge clk);
    etrig = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    logic [71:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R11 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), b);
      chk("R1 reset reg", {8'h00, b}, 16'h0000);
    end
    chk("R1 reset outputs", {13'd0, irq, txb, rxb}, 16'h0000);

    // R11 readback
    wr(3'd3, 8'hEF); wr(3'd4, 8'hBE);
    rd16(3'd3, w); chk("R11 companion readback", w, 16'hBEEF);

    // vector table
    for (int i = 0; i < 6; i++) begin
      v = VEC[i];
      setup(v[71:64], v[63:48], v[47:32]);
      for (int k = 0; k < int'(v[31:24]); k++) pulse(1'b1, 1'b1);
      rd16(3'd1, w); chk(VTAG[i], w, v[23:8]);
      rd(3'd0, b);   chk(VTAG[i], {8'h00, b}, {8'h00, v[7:0]});
    end

    // R3 external source: falling edges counted, ticks ignored
    setup(8'h03, 16'h0000, 16'h0000);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); eclk = 1'b1; repeat (4) @(negedge clk);
      eclk = 1'b0; repeat (4) @(negedge clk);
    end
    pulse(1'b1, 1'b1);
    rd16(3'd1, w); chk("R3 external edges", w, 16'h0003);

    // R3 baud internal source ignores tick_i
    setup(8'h11, 16'h0000, 16'h0000);
    for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0);
    rd16(3'd1, w); chk("R3 baud tick ignored", w, 16'h0000);

    // R8 both baud pulses, one cycle wide
    setup(8'h31, 16'hFFFF, 16'h8000);
    @(negedge clk); osc = 1'b1;
    @(negedge clk); osc = 1'b0; #1;
    chk("R8 tx/rx pulse", {14'd0, txb, rxb}, 16'h0003);
    @(negedge clk); #1;
    chk("R8 pulse width", {14'd0, txb, rxb}, 16'h0000);
    rd16(3'd1, w); chk("R8 baud reload", w, 16'h8000);
    rd(3'd0, b); chk("R8 no overflow flag", {8'h00, b}, 16'h0031);

    // R8 transmit only
    setup(8'h11, 16'hFFFF, 16'h8000);
    @(negedge clk); osc = 1'b1;
    @(negedge clk); osc = 1'b0; #1;
    chk("R8 tx only", {14'd0, txb, rxb}, 16'h0002);

    // R5 capture on trigger
    setup(8'h0C, 16'h5A5A, 16'h0000);
    trig_edge();
    rd16(3'd3, w); chk("R5 captured value", w, 16'h5A5A);
    rd(3'd0, b); chk("R5 trigger flag", {8'h00, b}, 16'h008C);
    chk("R9 irq from trigger flag", {15'd0, irq}, 16'h0001);

    // R7 trigger disabled
    setup(8'h04, 16'h1111, 16'h0000);
    trig_edge();
    rd16(3'd3, w); chk("R7 companion untouched", w, 16'h0000);
    rd16(3'd1, w); chk("R7 counter untouched", w, 16'h1111);
    rd(3'd0, b); chk("R7 flags untouched", {8'h00, b}, 16'h0004);
    chk("R7 irq low", {15'd0, irq}, 16'h0000);

    // R6 reload on trigger, run off
    setup(8'h08, 16'h0300, 16'h0777);
    trig_edge();
    rd16(3'd1, w); chk("R6 reload on trigger", w, 16'h0777);
    rd(3'd0, b); chk("R6 trigger flag", {8'h00, b}, 16'h0088);

    // R9 sticky until written
    repeat (10) @(negedge clk);
    rd(3'd0, b); chk("R9 flag held", {8'h00, b}, 16'h0088);
    wr(3'd0, 8'h08);
    chk("R9 irq cleared by write", {15'd0, irq}, 16'h0000);

    // R10 overflow and trigger in the same cycle, capture mode
    setup(8'h0D, 16'hFFFF, 16'h0000);
    @(negedge clk); etrig = 1'b0;
    @(negedge clk);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    rd16(3'd3, w); chk("R10 capture of 0xFFFF", w, 16'hFFFF);
    rd16(3'd1, w); chk("R10 counter wrapped", w, 16'h0000);
    rd(3'd0, b); chk("R10 both flags", {8'h00, b}, 16'h00CD);
    etrig = 1'b1;
    repeat (4) @(negedge clk);

    // R10 hardware set beats same-cycle write
    setup(8'h01, 16'hFFFF, 16'h0000);
    @(negedge clk); tick = 1'b1; we = 1'b1; addr = 3'd0; wdata = 8'h01;
    @(negedge clk); tick = 1'b0; we = 1'b0;
    rd(3'd0, b); chk("R10 set over write", {8'h00, b}, 16'h0041);

    done = 1'b1;
    finish_run();
  end
endmodule